// File: doc/BRIEF.md
# Receive Timestamp Latch Bank

This block records the time of arrival of received precision-time event frames. Whenever the receive path raises a per-frame strobe, the block copies the running 64-bit nanosecond clock into one of four capture slots. It then hands the slot number back to the receive path, together with a flag saying whether a capture took place. The receive path carries that number along with the frame. Later, software uses the number to fetch the stored time through a small read port.

A slot stays occupied until the upper 32-bit half of its time is read. The intended order is the lower half first, then the upper half. Reading only the lower half leaves the slot occupied. If a frame is lost before software sees it, its slot stays occupied and the bank has one fewer slot for new captures. That lasts until the slot is drained by an explicit upper-half read or by the whole-bank clear strobe. A four-bit occupancy vector shows which slots currently hold an uncollected time.

Top module: `rx_ts_latch_bank`

## Requirements
- R1: After reset, `slot_held` is 0000, `stamp_ok` is 0 and `rd_data` is 0.
- R2: A `stamp_req` sampled at a rising edge takes the lowest-numbered slot that is neither held nor being released at that edge. The result appears one cycle later as `stamp_ok`=1, with the slot number on `stamp_slot` (slot 0 is bit 0 of `slot_held`).
- R3: A slot that receives a capture shows its `slot_held` bit at 1 from the cycle in which `stamp_ok` reports it.
- R4: The stored value is `now_ns` as sampled at the capturing edge. It stays unchanged while the slot is held, however `now_ns` moves afterwards.
- R5: A read with `rd_hi`=0 returns bits 31:0 of the slot on `rd_data` one cycle later and leaves that slot's `slot_held` bit unchanged.
- R6: A read with `rd_hi`=1 returns bits 63:32 of the slot on `rd_data` one cycle later and clears that slot's `slot_held` bit at the same edge.
- R7: A `stamp_req` while all four slots are held gives `stamp_ok`=0 one cycle later and changes no stored value.
- R8: A capture and an upper-half read in the same cycle never both use the slot being read. The release wins, the capture goes to another free slot or is dropped, and the released slot can be captured again from the next cycle.
- R9: `clear_all` frees all four slots at the next edge. A `stamp_req` in that same cycle is not stamped.
- R10: With `stamp_req` low at an edge, `stamp_ok` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| now_ns | input | 64 | Running nanosecond time |
| stamp_req | input | 1 | Capture strobe for the current frame |
| clear_all | input | 1 | Release all slots |
| rd_en | input | 1 | Read strobe |
| rd_slot | input | 2 | Slot addressed by the read |
| rd_hi | input | 1 | 1 = upper half (releases the slot), 0 = lower half |
| stamp_ok | output | 1 | The previous cycle's strobe was stamped |
| stamp_slot | output | 2 | Slot used by the stamped frame |
| slot_held | output | 4 | Per-slot occupancy |
| rd_data | output | 32 | Read result, valid the cycle after `rd_en` |

## Verification
Most internal faults appear at the ports within one cycle. A wrong occupancy bit shows on `slot_held` right away. It also shows at the next capture, as a wrong `stamp_slot` or a wrongly dropped frame. A corrupted or overwritten stored value shows only when that slot is read, so the sequences read every captured slot after the clock has moved on and after further captures have been attempted. A wrong release-versus-capture priority shows as a frame stamped into a slot that was just read.

// File: rtl/rx_ts_latch_pkg.sv
package rx_ts_latch_pkg;
  localparam int unsigned DEF_SLOTS  = 4;
  localparam int unsigned DEF_TIME_W = 64;
  localparam int unsigned DEF_WORD_W = 32;
endpackage

// File: rtl/rx_ts_alloc.sv
// Lowest-index free slot finder; slots being released are excluded.
module rx_ts_alloc #(
  parameter int unsigned SLOTS = 4,
  localparam int unsigned IW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             req,
  input  logic [SLOTS-1:0] held,
  input  logic [SLOTS-1:0] rel,
  output logic [SLOTS-1:0] grant,
  output logic [IW-1:0]    grant_idx,
  output logic             grant_vld
);
  logic [SLOTS-1:0] avail;

  always_comb begin
    avail     = ~held & ~rel;
    grant     = '0;
    grant_idx = '0;
    grant_vld = 1'b0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (req && avail[i]) begin
        grant     = '0;
        grant[i]  = 1'b1;
        grant_idx = IW'(i);
        grant_vld = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx_ts_slot.sv
// One capture slot: occupancy flag plus the stored time.
module rx_ts_slot #(
  parameter int unsigned TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              rel,
  input  logic [TIME_W-1:0] now_ns,
  output logic              held,
  output logic [TIME_W-1:0] stamp
);
  logic held_nxt;
  logic stamp_en;

  always_comb begin
    held_nxt = held;
    if (rel)       held_nxt = 1'b0;
    else if (load) held_nxt = 1'b1;
    stamp_en = load & ~rel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= 1'b0;
    else        held <= held_nxt;
  end

  always_ff @(posedge clk) begin
    if (stamp_en) stamp <= now_ns;
  end
endmodule

// File: rtl/rx_ts_rdport.sv
// Registered half-word read of a chosen slot.
module rx_ts_rdport #(
  parameter int unsigned SLOTS  = 4,
  parameter int unsigned TIME_W = 64,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned IW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_en,
  input  logic [IW-1:0]                rd_slot,
  input  logic                         rd_hi,
  input  logic [SLOTS-1:0][TIME_W-1:0] stamps,
  output logic [WORD_W-1:0]            rd_data
);
  logic [TIME_W-1:0] sel_stamp;
  logic [WORD_W-1:0] word_nxt;

  always_comb begin
    sel_stamp = stamps[rd_slot];
    word_nxt  = rd_hi ? sel_stamp[WORD_W +: WORD_W] : sel_stamp[0 +: WORD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= word_nxt;
  end
endmodule

// File: rtl/rx_ts_latch_bank.sv
module rx_ts_latch_bank #(
  parameter int unsigned SLOTS  = rx_ts_latch_pkg::DEF_SLOTS,
  parameter int unsigned TIME_W = rx_ts_latch_pkg::DEF_TIME_W,
  parameter int unsigned WORD_W = rx_ts_latch_pkg::DEF_WORD_W,
  localparam int unsigned IW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] now_ns,
  input  logic              stamp_req,
  input  logic              clear_all,
  input  logic              rd_en,
  input  logic [IW-1:0]     rd_slot,
  input  logic              rd_hi,
  output logic              stamp_ok,
  output logic [IW-1:0]     stamp_slot,
  output logic [SLOTS-1:0]  slot_held,
  output logic [WORD_W-1:0] rd_data
);
  logic [SLOTS-1:0]             rel_mask;
  logic [SLOTS-1:0]             grant;
  logic [IW-1:0]                grant_idx;
  logic                         grant_vld;
  logic [SLOTS-1:0][TIME_W-1:0] stamps;
  logic                         ok_nxt;
  logic [IW-1:0]                slot_nxt;

  // Release decode: bulk clear covers every slot, an upper-half read one.
  always_comb begin
    rel_mask = '0;
    if (clear_all)
      rel_mask = '1;
    else if (rd_en && rd_hi)
      rel_mask[rd_slot] = 1'b1;
  end

  rx_ts_alloc #(.SLOTS(SLOTS)) u_alloc (
    .req       (stamp_req),
    .held      (slot_held),
    .rel       (rel_mask),
    .grant     (grant),
    .grant_idx (grant_idx),
    .grant_vld (grant_vld)
  );

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    rx_ts_slot #(.TIME_W(TIME_W)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (grant[g]),
      .rel    (rel_mask[g]),
      .now_ns (now_ns),
      .held   (slot_held[g]),
      .stamp  (stamps[g])
    );
  end

  rx_ts_rdport #(.SLOTS(SLOTS), .TIME_W(TIME_W), .WORD_W(WORD_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_slot (rd_slot),
    .rd_hi   (rd_hi),
    .stamps  (stamps),
    .rd_data (rd_data)
  );

  always_comb begin
    ok_nxt   = grant_vld;
    slot_nxt = grant_vld ? grant_idx : stamp_slot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stamp_ok   <= 1'b0;
      stamp_slot <= '0;
    end else begin
      stamp_ok   <= ok_nxt;
      stamp_slot <= slot_nxt;
    end
  end
endmodule

// File: rtl/rx_ts_latch_bank_chk.sv
module rx_ts_latch_bank_chk #(
  parameter int unsigned SLOTS = 4,
  parameter int unsigned IW    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stamp_req,
  input logic             clear_all,
  input logic             rd_en,
  input logic [IW-1:0]    rd_slot,
  input logic             rd_hi,
  input logic             stamp_ok,
  input logic [IW-1:0]    stamp_slot,
  input logic [SLOTS-1:0] slot_held
);
  p_ok_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stamp_ok |-> $past(stamp_req));

  p_ok_marks_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stamp_ok |-> slot_held[stamp_slot]);

  p_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stamp_req && (&slot_held)) |=> !stamp_ok);

  p_hi_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_hi) |=> !slot_held[$past(rd_slot)]);

  p_low_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_hi && !clear_all && slot_held[rd_slot]) |=> slot_held[$past(rd_slot)]);

  p_clear_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all |=> (slot_held == '0));

  p_clear_no_stamp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all |=> !stamp_ok);
endmodule

bind rx_ts_latch_bank rx_ts_latch_bank_chk #(.SLOTS(SLOTS), .IW(IW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stamp_req  (stamp_req),
  .clear_all  (clear_all),
  .rd_en      (rd_en),
  .rd_slot    (rd_slot),
  .rd_hi      (rd_hi),
  .stamp_ok   (stamp_ok),
  .stamp_slot (stamp_slot),
  .slot_held  (slot_held)
);

// File: tb/rx_ts_latch_bank_tb.sv
module rx_ts_latch_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] now_ns = '0;
  logic        stamp_req = 1'b0;
  logic        clear_all = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_slot = '0;
  logic        rd_hi = 1'b0;
  logic        stamp_ok;
  logic [1:0]  stamp_slot;
  logic [3:0]  slot_held;
  logic [31:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  rx_ts_latch_bank u_dut (
    .clk(clk), .rst_n(rst_n), .now_ns(now_ns), .stamp_req(stamp_req),
    .clear_all(clear_all), .rd_en(rd_en), .rd_slot(rd_slot), .rd_hi(rd_hi),
    .stamp_ok(stamp_ok), .stamp_slot(stamp_slot), .slot_held(slot_held),
    .rd_data(rd_data)
  );

  typedef struct {
    string       tag;
    bit          ok;
    logic [1:0]  slot;
    logic [3:0]  held;
    bit          has_rd;
    logic [31:0] data;
  } exp_t;

  exp_t        sb_q[$];
  logic [3:0]  m_held = '0;
  logic [63:0] m_store [4];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and predicts the next-cycle outputs.
  task automatic step(input string tag, input bit cap, input logic [63:0] t,
                      input bit ren, input logic [1:0] rs, input bit hi, input bit clr);
    exp_t e;
    logic [3:0] rel;
    @(negedge clk);
    now_ns = t; stamp_req = cap; rd_en = ren; rd_slot = rs; rd_hi = hi; clear_all = clr;
    rel = '0;
    if (clr) rel = 4'hF;
    else if (ren && hi) rel[rs] = 1'b1;
    e.tag = tag; e.ok = 1'b0; e.slot = '0; e.has_rd = ren; e.data = '0;
    if (ren) e.data = hi ? m_store[rs][63:32] : m_store[rs][31:0];
    if (cap) begin
      for (int i = 3; i >= 0; i--) begin
        if (!m_held[i] && !rel[i]) begin
          e.ok = 1'b1; e.slot = 2'(i);
        end
      end
    end
    m_held = m_held & ~rel;
    if (e.ok) begin
      m_held[e.slot]  = 1'b1;
      m_store[e.slot] = t;
    end
    e.held = m_held;
    sb_q.push_back(e);
  endtask

  task automatic idle(input string tag, input logic [63:0] t);
    step(tag, 1'b0, t, 1'b0, 2'd0, 1'b0, 1'b0);
  endtask

  // Monitor: compares each cycle's outputs against the queued prediction.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        chk({e.tag, " stamp_ok"}, 64'(stamp_ok), 64'(e.ok));
        if (e.ok) chk({e.tag, " stamp_slot"}, 64'(stamp_slot), 64'(e.slot));
        chk({e.tag, " slot_held"}, 64'(slot_held), 64'(e.held));
        if (e.has_rd) chk({e.tag, " rd_data"}, 64'(rd_data), 64'(e.data));
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    #1;
    chk("R1 held", 64'(slot_held), 64'h0);
    chk("R1 ok", 64'(stamp_ok), 64'h0);
    chk("R1 rd_data", 64'(rd_data), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;

    idle("R10 idle", 64'h5);
    // R2 R3 R4: fill all slots in order with distinct times
    step("R2 fill0", 1, 64'h0000_0011_1000_0001, 0, 0, 0, 0);
    step("R2 fill1", 1, 64'h0000_0022_2000_0002, 0, 0, 0, 0);
    idle("R10 gap", 64'h9999);
    step("R3 fill2", 1, 64'hABCD_0033_3000_0003, 0, 0, 0, 0);
    step("R3 fill3", 1, 64'hFFFF_FFFF_4000_0004, 0, 0, 0, 0);
    // R7: bank full, frame dropped, contents untouched
    step("R7 full", 1, 64'hDEAD_BEEF_DEAD_BEEF, 0, 0, 0, 0);
    step("R7 keep2", 0, 64'h1, 1, 2'd2, 0, 0);
    // R5: low read keeps slot held
    step("R5 lo1", 0, 64'h2, 1, 2'd1, 0, 0);
    step("R4 lo3 held", 0, 64'h3, 1, 2'd3, 0, 0);
    // R6: high read returns upper half and frees slot
    step("R6 hi1", 0, 64'h4, 1, 2'd1, 1, 0);
    // R2: lowest free is slot 1
    step("R2 refill1", 1, 64'h0000_0055_5000_0005, 0, 0, 0, 0);
    // R8: release slot 0 and capture in same cycle; all others held -> dropped
    step("R8 same", 1, 64'h0000_0066_6000_0006, 1, 2'd0, 1, 0);
    step("R8 reuse", 1, 64'h0000_0077_7000_0007, 0, 0, 0, 0);
    step("R4 lo0 new", 0, 64'h8, 1, 2'd0, 0, 0);
    step("R4 hi0 new", 0, 64'h9, 1, 2'd0, 1, 0);
    // R9: bulk clear with simultaneous capture
    step("R9 clear", 1, 64'h0000_0088_8000_0008, 0, 0, 0, 1);
    idle("R9 after", 64'hA);
    // R8: upper-half read of a free slot 0 with capture -> goes to slot 1
    step("R8 freeslot", 1, 64'h0000_0099_9000_0009, 1, 2'd0, 1, 0);
    step("R2 next", 1, 64'h0000_00AA_A000_000A, 0, 0, 0, 0);
    // R4: clock moves on, stored values held
    for (int k = 0; k < 5; k++) idle("R4 run", 64'(k) * 64'h1234_5678);
    step("R4 lo1", 0, 64'hB, 1, 2'd1, 0, 0);
    step("R4 hi1", 0, 64'hC, 1, 2'd1, 1, 0);
    step("R6 hi2", 0, 64'hD, 1, 2'd2, 1, 0);
    step("R2 after", 1, 64'h0000_00BB_B000_000B, 0, 0, 0, 0);
    step("R9 clear2", 0, 64'hE, 0, 0, 0, 1);
    idle("R10 end", 64'hF);
    idle("R10 end2", 64'hF);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule